// File: doc/BRIEF.md
# Multiplier-Free Eight-Point Cosine Transform Engine

This block turns a block of eight signed samples into the eight coefficients of the forward one-dimensional discrete cosine transform without any multiplier. A butterfly first folds the samples into four pair-sums and four pair-differences. The even-indexed coefficients draw on the sums and the odd-indexed coefficients on the differences, so each folded term is formed once and shared by four coefficient units. Each of the eight units then reads one bit of every folded term per clock, least significant bit first. For every magnitude bit of its fixed cosine constants, the unit counts how many active terms have a one in that column, with separate counts for positive and negative constants. The signed difference of the two counts is weighted by the bit position and added into a short column accumulator. After the scan, the six column words are shifted and added serially, then rounded to the output width.

Work proceeds in slots of nine cycles, one cycle per bit of a folded term. A block is taken only on the last cycle of a slot, and every stage hands its data forward at that same boundary. Blocks can therefore stream at one per slot. The source sees back-pressure as `in_ready` held low for the other eight cycles of each slot. It must hold `in_valid` and the samples steady until a cycle in which `in_ready` is high. The output side has no back-pressure: `out_valid` is a one-cycle strobe, and the coefficient bus keeps its value until the next strobe.

Top module: `dct8_counter_engine`

## Requirements
- R1: `in_ready` is high in the first cycle after reset and then in exactly one cycle out of every nine. A block is taken at a clock edge only where `in_valid` and `in_ready` are both high.
- R2: With sample n at `in_samples[8n+7:8n]`, coefficient k appears at `out_coefs[16k+15:16k]` as signed 16 bits. It equals floor((S_k + 64) / 128), where S_k = sum over n of x_n * C(k,n). C(k,n) = round(128 * a_k * cos((2n+1) k pi / 16)), with a_0 = sqrt(1/8) and a_k = 1/2 for k > 0.
- R3: R2 holds exactly for extreme blocks: all samples -128, all samples +127, alternating -128/+127, a single nonzero sample, and all zeros.
- R4: `out_valid` is high for a single cycle, at the 18th rising edge after the edge that took the block.
- R5: When blocks are taken back to back, they are accepted nine cycles apart and their results appear nine cycles apart, in the order taken.
- R6: `in_valid` asserted in cycles where `in_ready` is low has no effect: no result strobe ever follows from it.
- R7: Synchronous reset drops `out_valid` and raises `in_ready`. A block taken before a reset produces no result after it.
- R8: Between strobes, `out_coefs` keeps the value it had at the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source presents a sample block |
| in_ready | output | 1 | Engine takes a block on this cycle's edge |
| in_samples | input | 64 | Eight two's-complement samples, sample n at bits [8n+7:8n] |
| out_valid | output | 1 | One-cycle strobe marking new coefficients |
| out_coefs | output | 128 | Eight signed coefficients, coefficient k at bits [16k+15:16k] |

## Verification
The hardest state to reach is a sign-bit column that holds mixed counts from constants of both signs while the folded term sits at its full-scale negative value. In that state the pair-sum of two -128 samples is -256, and the term subtracted in the last scan cycle is at its largest. Blocks of all -128 samples and alternating extremes drive the accumulators to their bounds there. Streaming several blocks back to back keeps a scan, a reduction and an output update all active in the same slot. Separate tasks raise `in_valid` only in the eight closed cycles of a slot, and reset a block partway through its scan, to show that neither leaves a result behind.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int NPT    = 8;
  localparam int HALF   = NPT / 2;
  localparam int MAG_W  = 6;
  localparam int FRAC   = 7;
  localparam int CNT_W  = $clog2(HALF) + 1;
  localparam int DIF_W  = CNT_W + 1;

  // Folded constant for unit k on folded row n (rows n and 7-n share it).
  function automatic int fold_coef(input int k, input int n);
    int r [4];
    case (k)
      0:       r = '{45, 45, 45, 45};
      1:       r = '{63, 53, 36, 12};
      2:       r = '{59, 24, -24, -59};
      3:       r = '{53, -12, -63, -36};
      4:       r = '{45, -45, -45, 45};
      5:       r = '{36, -63, 12, 53};
      6:       r = '{24, -59, 59, -24};
      default: r = '{12, -36, 53, -63};
    endcase
    return r[n];
  endfunction

  // Rows whose constant has magnitude bit b set and the requested sign.
  function automatic logic [HALF-1:0] col_mask(input int k, input int b, input bit want_neg);
    logic [HALF-1:0] m;
    int c;
    int a;
    for (int n = 0; n < HALF; n++) begin
      c = fold_coef(k, n);
      a = (c < 0) ? -c : c;
      m[n] = ((c < 0) == want_neg) && (((a >> b) & 1) == 1);
    end
    return m;
  endfunction
endpackage

// File: rtl/dct8_butterfly.sv
module dct8_butterfly import dct8_pkg::*; #(
  parameter int IN_W = 8
) (
  input  logic [NPT*IN_W-1:0]   samples,
  output logic [HALF-1:0][IN_W:0] sum_o,
  output logic [HALF-1:0][IN_W:0] dif_o
);
  for (genvar n = 0; n < HALF; n++) begin : g_pair
    logic [IN_W:0] lo_x, hi_x;
    assign lo_x = {samples[n*IN_W + IN_W-1], samples[n*IN_W +: IN_W]};
    assign hi_x = {samples[(NPT-1-n)*IN_W + IN_W-1], samples[(NPT-1-n)*IN_W +: IN_W]};
    assign sum_o[n] = lo_x + hi_x;
    assign dif_o[n] = lo_x - hi_x;
  end
endmodule

// File: rtl/dct8_colcnt.sv
module dct8_colcnt import dct8_pkg::*; (
  input  logic [HALF-1:0]         pos_bits,
  input  logic [HALF-1:0]         neg_bits,
  output logic signed [DIF_W-1:0] diff
);
  logic [CNT_W-1:0] n_pos, n_neg;

  always_comb begin
    n_pos = '0;
    n_neg = '0;
    for (int i = 0; i < HALF; i++) begin
      n_pos = n_pos + CNT_W'(pos_bits[i]);
      n_neg = n_neg + CNT_W'(neg_bits[i]);
    end
    diff = $signed({1'b0, n_pos}) - $signed({1'b0, n_neg});
  end
endmodule

// File: rtl/dct8_ipu.sv
module dct8_ipu import dct8_pkg::*; #(
  parameter int K     = 0,
  parameter int BW    = 9,
  parameter int OUT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [HALF-1:0]           row_bits,
  input  logic [$clog2(BW)-1:0]     ph,
  input  logic                      res_en,
  output logic signed [OUT_W-1:0]   coef_o
);
  localparam int PH_W  = $clog2(BW);
  localparam int LAST  = BW - 1;
  localparam int ACC_W = BW + CNT_W;
  localparam int SUM_W = ACC_W + MAG_W;
  localparam int LIM   = HALF << (BW - 1);

  logic signed [DIF_W-1:0] diff  [MAG_W];
  logic signed [ACC_W-1:0] term  [MAG_W];
  logic signed [ACC_W-1:0] acc_q [MAG_W];
  logic signed [ACC_W-1:0] red_w [MAG_W];
  logic signed [SUM_W-1:0] red_sum, addend, rounded;
  logic                    at_last;

  assign at_last = (ph == PH_W'(LAST));

  for (genvar b = 0; b < MAG_W; b++) begin : g_col
    logic signed [ACC_W-1:0] shifted;
    dct8_colcnt u_cnt (
      .pos_bits (row_bits & col_mask(K, b, 1'b0)),
      .neg_bits (row_bits & col_mask(K, b, 1'b1)),
      .diff     (diff[b])
    );
    assign shifted = ACC_W'(diff[b]) <<< ph;
    // Sign bit of a folded term weighs negative.
    assign term[b] = at_last ? -shifted : shifted;

    a_r2_acc_bound: assert property (@(posedge clk) disable iff (rst)
      (acc_q[b] <= ACC_W'(LIM)) && (acc_q[b] >= -ACC_W'(LIM)));
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < MAG_W; b++) begin
      if (rst) begin
        acc_q[b] <= '0;
        red_w[b] <= '0;
      end else if (at_last) begin
        red_w[b] <= acc_q[b] + term[b];
        acc_q[b] <= '0;
      end else begin
        acc_q[b] <= acc_q[b] + term[b];
      end
    end
  end

  // Serial reduction: one column word per cycle during the following slot.
  always_comb begin
    addend = '0;
    for (int b = 0; b < MAG_W; b++)
      if (ph == PH_W'(b)) addend = SUM_W'(red_w[b]) <<< b;
  end

  assign rounded = (red_sum + SUM_W'(1 << (FRAC - 1))) >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      red_sum <= '0;
      coef_o  <= '0;
    end else if (at_last) begin
      red_sum <= '0;
      if (res_en) coef_o <= OUT_W'(rounded);
    end else begin
      red_sum <= red_sum + addend;
    end
  end
endmodule

// File: rtl/dct8_counter_engine.sv
module dct8_counter_engine import dct8_pkg::*; #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NPT*IN_W-1:0]    in_samples,
  output logic                   out_valid,
  output logic [NPT*OUT_W-1:0]   out_coefs
);
  localparam int BW   = IN_W + 1;
  localparam int PH_W = $clog2(BW);
  localparam int LAST = BW - 1;

  logic [PH_W-1:0]            ph;
  logic                       accept, scan_vld, red_vld;
  logic [HALF-1:0][BW-1:0]    fold_s, fold_d, sh_s, sh_d;
  logic [HALF-1:0]            bit_s, bit_d;
  logic signed [OUT_W-1:0]    coef_w [NPT];

  assign in_ready = (ph == PH_W'(LAST));
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_W'(LAST);
    else     ph <= (ph == PH_W'(LAST)) ? '0 : ph + 1'b1;
  end

  dct8_butterfly #(.IN_W(IN_W)) u_fold (
    .samples (in_samples),
    .sum_o   (fold_s),
    .dif_o   (fold_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_vld  <= 1'b0;
      red_vld   <= 1'b0;
      out_valid <= 1'b0;
      sh_s      <= '0;
      sh_d      <= '0;
    end else begin
      if (in_ready) begin
        scan_vld  <= accept;
        red_vld   <= scan_vld;
        out_valid <= red_vld;
      end else begin
        out_valid <= 1'b0;
      end
      for (int n = 0; n < HALF; n++) begin
        sh_s[n] <= accept ? fold_s[n] : (sh_s[n] >> 1);
        sh_d[n] <= accept ? fold_d[n] : (sh_d[n] >> 1);
      end
    end
  end

  for (genvar n = 0; n < HALF; n++) begin : g_bits
    assign bit_s[n] = sh_s[n][0] & scan_vld;
    assign bit_d[n] = sh_d[n][0] & scan_vld;
  end

  for (genvar k = 0; k < NPT; k++) begin : g_unit
    logic [HALF-1:0] rows;
    if (k % 2 == 0) begin : g_even
      assign rows = bit_s;
    end else begin : g_odd
      assign rows = bit_d;
    end
    dct8_ipu #(.K(k), .BW(BW), .OUT_W(OUT_W)) u_ipu (
      .clk      (clk),
      .rst      (rst),
      .row_bits (rows),
      .ph       (ph),
      .res_en   (red_vld),
      .coef_o   (coef_w[k])
    );
    assign out_coefs[k*OUT_W +: OUT_W] = coef_w[k];
  end

  a_r1_ready_once: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r4_from_reduction: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(red_vld));
  a_r5_scan_to_reduce: assert property (@(posedge clk) disable iff (rst)
    (scan_vld && in_ready) |=> red_vld);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_coefs));
endmodule

// File: tb/test_dct8_counter_engine.sv
module test_dct8_counter_engine;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_samples = '0;
  logic         out_valid;
  logic [127:0] out_coefs;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int exp_c [0:63][0:7];
  int exp_t [0:63];
  int n_exp = 0, n_got = 0, n_strobe = 0;
  bit prev_v = 1'b0;
  bit done = 1'b0;

  dct8_counter_engine i_dct8_counter_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .out_valid(out_valid), .out_coefs(out_coefs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int got, input int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  function automatic int cref(input int k, input int n);
    real a, v;
    a = (k == 0) ? $sqrt(0.125) : 0.5;
    v = 128.0 * a * $cos(real'((2*n+1)*k) * PI / 16.0);
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic int dref(input logic [63:0] blk, input int k);
    int s = 0;
    for (int n = 0; n < 8; n++)
      s += int'($signed(blk[8*n +: 8])) * cref(k, n);
    return (s + 64) >>> 7;
  endfunction

  // Collector: compares every strobe with the oldest pending block.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_strobe++;
        chk("R4", "strobe width", int'(prev_v), 0);
        if (n_got >= n_exp) begin
          chk("R6", "unexpected strobe", 1, 0);
        end else begin
          chk("R4", "latency", cyc - exp_t[n_got], 18);
          for (int k = 0; k < 8; k++)
            chk("R2", $sformatf("blk%0d coef%0d", n_got, k),
                int'($signed(out_coefs[16*k +: 16])), exp_c[n_got][k]);
          n_got++;
        end
      end
      prev_v = out_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R7", "ready after reset", int'(in_ready), 1);
    chk("R7", "valid after reset", int'(out_valid), 0);
  endtask

  task automatic send(input logic [63:0] blk);
    while (!in_ready) @(negedge clk);
    in_samples = blk;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_t[n_exp] = cyc;
    for (int k = 0; k < 8; k++) exp_c[n_exp][k] = dref(blk, k);
    n_exp++;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
    chk("R4", "all results returned", n_got, n_exp);
  endtask

  function automatic logic [63:0] fill(input logic [7:0] v);
    logic [63:0] b;
    for (int n = 0; n < 8; n++) b[8*n +: 8] = v;
    return b;
  endfunction

  task automatic t_random_single();
    for (int i = 0; i < 4; i++) begin
      send({$urandom, $urandom});
      drain();  // R2
    end
  endtask

  task automatic t_extremes();
    send(fill(8'h80));                 // R3 all most negative
    drain();
    send(fill(8'h7F));                 // R3 all most positive
    drain();
    send(64'h7F807F807F807F80);        // R3 alternating
    drain();
    send(64'h00000000_7F000000);       // R3 single sample at n=3
    drain();
    send(64'h0);                       // R3 zeros
    drain();
    send(64'h807F807F807F807F);        // R3 alternating, swapped
    drain();
  endtask

  task automatic t_stream();
    int t0;
    send({$urandom, $urandom});
    t0 = exp_t[n_exp-1];
    for (int i = 1; i < 5; i++) begin
      send({$urandom, $urandom});
      chk("R5", "accept spacing", exp_t[n_exp-1] - exp_t[n_exp-2], 9);
    end
    chk("R5", "stream span", exp_t[n_exp-1] - t0, 36);
    send(fill(8'h80));
    send(fill(8'h7F));
    drain();
  endtask

  task automatic t_ready_gap();
    int highs = 0;
    for (int i = 0; i < 27; i++) begin
      highs += int'(in_ready);
      @(negedge clk);
    end
    chk("R1", "ready cycles in 27", highs, 3);
    begin
      int s0 = n_strobe;
      in_samples = fill(8'h55);
      for (int i = 0; i < 18; i++) begin
        in_valid = !in_ready;
        @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (30) @(negedge clk);
      chk("R6", "strobes from closed cycles", n_strobe - s0, 0);
    end
  endtask

  task automatic t_hold();
    logic [127:0] snap;
    send(64'h0123456789ABCDEF);
    drain();
    snap = out_coefs;
    repeat (20) @(negedge clk);
    chk("R8", "coefs held", int'(out_coefs == snap), 1);
  endtask

  task automatic t_mid_reset();
    int s0;
    send(fill(8'h33));
    n_exp--;
    repeat (5) @(negedge clk);
    s0 = n_strobe;
    do_reset();
    repeat (30) @(negedge clk);
    chk("R7", "strobes after reset", n_strobe - s0, 0);
    send(fill(8'hC0));
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk("R4", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_random_single();
    t_extremes();
    t_stream();
    t_ready_gap();
    t_hold();
    t_mid_reset();
    finish_run();
  end
endmodule